// File: doc/BRIEF.md
# Per-Processor Software Interrupt Register

This block is the interrupt register that sits beside one processor. It holds a 32-bit pending word that has two fields. The upper field, bits 31 to 17, holds software interrupts. Software raises them through a set port and drops them through a clear port. The lower field, bits 15 to 1, holds hardware interrupt levels. The system router side raises and drops these bits with per-bit strobes. Bits 16 and 0 always read as zero.

The block drives the processor's sixteen interrupt level lines from a register. Each software bit moves down sixteen places onto a level line, so bit 31 lands on level 15 and bit 17 on level 1. The level lines are then ORed with the level vector that the router delivers. Software reaches the block through a single-cycle strobe: a valid bit, a 2-bit word address and 32 bits of data. Word 1 clears bits and word 2 sets them. A combinational read port returns the pending word at word 0 and returns zero at every other word.

The asynchronous reset is active low and its release is synchronised inside the block.

Top module: `psi_cpu_softirq`

## Requirements
- R1: After reset the pending word reads 0x00000000 and `cpu_level` is 0x0000.
- R2: `rd_data` returns the pending word when `rd_addr` is 0 and returns 0 when `rd_addr` is 1, 2 or 3.
- R3: A write with `wr_valid` high and `wr_addr` = 2 ORs `wr_data & 0xFFFE0000` into the pending word.
- R4: A write with `wr_valid` high and `wr_addr` = 1 clears the pending bits selected by `wr_data & 0xFFFE0000`.
- R5: In a clear write (word 1), a 1 in `wr_data` bit 14 also clears pending bit 31, whatever `wr_data` bit 31 holds. It does not clear pending bit 14.
- R6: Software set and clear writes never change pending bits 16 down to 0.
- R7: `rtr_set[i]` sets pending bit i and `rtr_clr[i]` clears it, for i = 1 to 15, and set wins when both are high. Bit 0 of both vectors is ignored. Router strobes never change bits 31 down to 16.
- R8: `cpu_level` is registered. One clock after the pending word and `rtr_level` are sampled, it equals `{pending[31:17], 1'b0} | rtr_level`.
- R9: Writes to word 0 or word 3 leave the pending word unchanged.
- R10: A strobe with `wr_valid` low changes nothing, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe valid |
| wr_addr | input | 2 | Write word address (1 clear, 2 set) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (pending word at word 0, zero elsewhere) |
| rtr_set | input | 16 | Router per-bit set strobes for the hardware field |
| rtr_clr | input | 16 | Router per-bit clear strobes for the hardware field |
| rtr_level | input | 16 | Level vector routed from the system router |
| cpu_level | output | 16 | Registered interrupt level lines to the processor |

## Verification
The hardest case to reach is a clear write in which bit 14 is set and bit 31 is not. This write must still drop pending bit 31 while leaving the hardware copy of bit 14 alone. Reaching it takes several steps in order. The router must first raise hardware bit 14 and software must fill the upper field. Only then does the aliased clear go in, and the read port has to show both outcomes. A further hard case is a router set and clear of the same bit in the same cycle. The bench drives both cases directly. It then runs a long random phase in which addresses, router strobes and level inputs all overlap, and a behavioural model is compared against the design on every clock.

// File: rtl/psi_pkg.sv
package psi_pkg;

  // Word addresses decoded by the write and read ports.
  typedef enum logic [1:0] {
    WORD_PEND = 2'd0,
    WORD_CLR  = 2'd1,
    WORD_SET  = 2'd2,
    WORD_RSVD = 2'd3
  } psi_word_e;

  localparam int unsigned PSI_ADDR_W = 2;

  // Mask of the software field: bits DW-1 down to LN+1.
  function automatic logic [63:0] psi_soft_mask(input int unsigned dw, input int unsigned ln);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i > ln && i < dw) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Mask of the hardware field: bits LN-1 down to 1.
  function automatic logic [63:0] psi_hw_mask(input int unsigned ln);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 1; i < 64; i++) begin
      if (i < ln) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/psi_rst_sync.sv
module psi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/psi_wr_decode.sv
module psi_wr_decode
  import psi_pkg::*;
#(
  parameter int unsigned LVL_N = 16
) (
  input  logic                    wr_valid,
  input  logic [PSI_ADDR_W-1:0]   wr_addr,
  input  logic [2*LVL_N-1:0]      wr_data,
  output logic [2*LVL_N-1:0]      soft_set,
  output logic [2*LVL_N-1:0]      soft_clr
);

  localparam int unsigned DATA_W    = 2 * LVL_N;
  localparam int unsigned ALIAS_SRC = LVL_N - 2;
  localparam int unsigned ALIAS_DST = DATA_W - 1;
  localparam logic [63:0] SOFT_W64  = psi_soft_mask(DATA_W, LVL_N);
  localparam logic [DATA_W-1:0] SOFT_MASK = SOFT_W64[DATA_W-1:0];

  logic              hit_set;
  logic              hit_clr;
  logic [DATA_W-1:0] alias_v;
  logic [DATA_W-1:0] clr_raw;

  always_comb begin
    hit_set = wr_valid && (wr_addr == WORD_SET);
    hit_clr = wr_valid && (wr_addr == WORD_CLR);
  end

  // The alias bit joins the clear mask before the field mask is applied.
  always_comb begin
    alias_v            = '0;
    alias_v[ALIAS_DST] = wr_data[ALIAS_SRC];
    clr_raw            = wr_data | alias_v;
  end

  always_comb begin
    soft_set = hit_set ? (wr_data & SOFT_MASK) : '0;
    soft_clr = hit_clr ? (clr_raw & SOFT_MASK) : '0;
  end

endmodule

// File: rtl/psi_pend_reg.sv
module psi_pend_reg
  import psi_pkg::*;
#(
  parameter int unsigned LVL_N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*LVL_N-1:0]  soft_set,
  input  logic [2*LVL_N-1:0]  soft_clr,
  input  logic [LVL_N-1:0]    hw_set,
  input  logic [LVL_N-1:0]    hw_clr,
  output logic [2*LVL_N-1:0]  pend_q
);

  localparam int unsigned DATA_W = 2 * LVL_N;
  localparam logic [63:0] SOFT_W64 = psi_soft_mask(DATA_W, LVL_N);
  localparam logic [63:0] HW_W64   = psi_hw_mask(LVL_N);
  localparam logic [DATA_W-1:0] SOFT_MASK = SOFT_W64[DATA_W-1:0];
  localparam logic [LVL_N-1:0]  HW_MASK   = HW_W64[LVL_N-1:0];

  logic [DATA_W-1:0] pend_d;
  logic [DATA_W-1:0] soft_d;
  logic [LVL_N-1:0]  hw_d;
  logic [LVL_N-1:0]  hw_set_m;
  logic [LVL_N-1:0]  hw_clr_m;
  logic              soft_act;
  logic              hw_act;
  logic              pend_en;

  always_comb begin
    hw_set_m = hw_set & HW_MASK;
    hw_clr_m = hw_clr & HW_MASK;
    soft_act = (|soft_set) || (|soft_clr);
    hw_act   = (|hw_set_m) || (|hw_clr_m);
    pend_en  = soft_act || hw_act;
  end

  // Software field: clear then set, restricted to the field.
  always_comb begin
    soft_d = ((pend_q & ~soft_clr) | soft_set) & SOFT_MASK;
  end

  // Hardware field: set wins over clear on the same bit.
  always_comb begin
    hw_d = ((pend_q[LVL_N-1:0] & ~hw_clr_m) | hw_set_m) & HW_MASK;
  end

  always_comb begin
    pend_d               = soft_d;
    pend_d[LVL_N-1:0]    = hw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  // R6
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_act |=> $stable(pend_q[DATA_W-1:LVL_N+1]));

  // R7
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|hw_set[LVL_N-1:1]) || (|hw_clr[LVL_N-1:1])) |=> $stable(pend_q[LVL_N-1:0]));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 1'b0) && (pend_q[LVL_N] == 1'b0));

  // R3
  set_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|soft_set) |=> ((pend_q & $past(soft_set)) == $past(soft_set)));

  // R4
  clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|soft_clr) |=> ((pend_q & $past(soft_clr)) == '0));

  // R7
  hw_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set[LVL_N-1:1]) |=> ((pend_q[LVL_N-1:1] & $past(hw_set[LVL_N-1:1])) == $past(hw_set[LVL_N-1:1])));

endmodule

// File: rtl/psi_level_out.sv
module psi_level_out #(
  parameter int unsigned LVL_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-2:0] soft_bits,
  input  logic [LVL_N-1:0] rtr_level,
  output logic [LVL_N-1:0] lvl_q
);

  logic [LVL_N-1:0] lvl_d;
  logic             lvl_en;

  // Line 0 comes only from the router; lines 1 and up merge one soft bit each.
  assign lvl_d[0] = rtr_level[0];

  for (genvar g = 1; g < LVL_N; g++) begin : g_line
    assign lvl_d[g] = rtr_level[g] | soft_bits[g-1];
  end

  always_comb begin
    lvl_en = (lvl_d != lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  // R8
  lvl_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|soft_bits) |=> (|lvl_q[LVL_N-1:1]));

  // R8
  lvl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_bits == '0) && (rtr_level == '0)) |=> (lvl_q == '0));

  // R8
  lvl_router_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtr_level != '0) |=> ((lvl_q & $past(rtr_level)) == $past(rtr_level)));

endmodule

// File: rtl/psi_cpu_softirq.sv
module psi_cpu_softirq
  import psi_pkg::*;
#(
  parameter int unsigned LVL_N       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    wr_valid,
  input  logic [PSI_ADDR_W-1:0]   wr_addr,
  input  logic [2*LVL_N-1:0]      wr_data,
  input  logic [PSI_ADDR_W-1:0]   rd_addr,
  output logic [2*LVL_N-1:0]      rd_data,
  input  logic [LVL_N-1:0]        rtr_set,
  input  logic [LVL_N-1:0]        rtr_clr,
  input  logic [LVL_N-1:0]        rtr_level,
  output logic [LVL_N-1:0]        cpu_level
);

  localparam int unsigned DATA_W    = 2 * LVL_N;
  localparam int unsigned ALIAS_SRC = LVL_N - 2;

  logic              rst_n;
  logic [DATA_W-1:0] soft_set;
  logic [DATA_W-1:0] soft_clr;
  logic [DATA_W-1:0] pend_q;

  psi_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  psi_wr_decode #(
    .LVL_N (LVL_N)
  ) u_dec (
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .soft_set (soft_set),
    .soft_clr (soft_clr)
  );

  psi_pend_reg #(
    .LVL_N (LVL_N)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_set (soft_set),
    .soft_clr (soft_clr),
    .hw_set   (rtr_set),
    .hw_clr   (rtr_clr),
    .pend_q   (pend_q)
  );

  psi_level_out #(
    .LVL_N (LVL_N)
  ) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_bits (pend_q[DATA_W-1:LVL_N+1]),
    .rtr_level (rtr_level),
    .lvl_q     (cpu_level)
  );

  always_comb begin
    rd_data = (rd_addr == WORD_PEND) ? pend_q : '0;
  end

  // R5
  alias_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_addr == WORD_CLR) && wr_data[ALIAS_SRC]) |=> !pend_q[DATA_W-1]);

  // R9
  rsvd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ((wr_addr == WORD_PEND) || (wr_addr == WORD_RSVD)) && !(|rtr_set) && !(|rtr_clr))
      |=> $stable(pend_q));

  // R10
  idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !(|rtr_set) && !(|rtr_clr)) |=> $stable(pend_q));

endmodule

// File: tb/psi_cpu_softirq_test.sv
`timescale 1ns/1ps
module psi_cpu_softirq_test;

  logic        clk;
  logic        arst_n;
  logic        wr_valid;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [15:0] rtr_set;
  logic [15:0] rtr_clr;
  logic [15:0] rtr_level;
  logic [15:0] cpu_level;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;

  // Behavioural reference state
  bit [31:0] m_pend;
  bit [15:0] m_level;

  psi_cpu_softirq uut (
    .clk       (clk),
    .arst_n    (arst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rtr_set   (rtr_set),
    .rtr_clr   (rtr_clr),
    .rtr_level (rtr_level),
    .cpu_level (cpu_level)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Model updated at each rising edge from the inputs held since the last edge.
  always @(posedge clk) begin
    bit [31:0] c;
    if (!arst_n) begin
      m_pend  = 0;
      m_level = 0;
    end else begin
      m_level = {m_pend[31:17], 1'b0} | rtr_level;
      if (wr_valid && wr_addr == 2) m_pend = m_pend | (wr_data & 32'hFFFE0000);
      if (wr_valid && wr_addr == 1) begin
        c = wr_data;
        if (c[14]) c[31] = 1'b1;
        m_pend = m_pend & ~(c & 32'hFFFE0000);
      end
      for (int i = 1; i < 16; i++) begin
        if (rtr_set[i]) m_pend[i] = 1'b1;
        else if (rtr_clr[i]) m_pend[i] = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model (R2, R8 and all update rules).
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R8 model level", {16'h0, cpu_level}, {16'h0, m_level});
      chk("R2 model read", rd_data, (rd_addr == 0) ? m_pend : 32'h0);
    end
  end

  task automatic idle_inputs();
    wr_valid = 0; wr_addr = 0; wr_data = 0;
    rtr_set = 0; rtr_clr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic v, input logic [1:0] a, input logic [31:0] d);
    wr_valid = v; wr_addr = a; wr_data = d;
    step();
    idle_inputs();
    step();
  endtask

  task automatic rtr(input logic [15:0] s, input logic [15:0] c);
    rtr_set = s; rtr_clr = c;
    step();
    idle_inputs();
    step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    arst_n = 0; rd_addr = 0; rtr_level = 0;
    idle_inputs();
    repeat (3) step();
    arst_n = 1;
    repeat (4) step();
    cmp_en = 1;

    // R1 reset state
    chk("R1 pending after reset", rd_data, 32'h0);
    chk("R1 level after reset", {16'h0, cpu_level}, 32'h0);

    // R3 R6 set all soft bits; lower bits untouched
    wr(1, 2, 32'hFFFF_FFFF);
    chk("R3 R6 set write", rd_data, 32'hFFFE_0000);
    chk("R8 level from soft", {16'h0, cpu_level}, 32'h0000_FFFE);

    // R7 router raises hardware bits, bit 0 ignored
    rtr(16'hFFFF, 16'h0000);
    chk("R7 router set", rd_data, 32'hFFFE_FFFE);

    // R5 aliased clear: bit 14 in data drops bit 31, hw bit 14 stays
    wr(1, 1, 32'h0000_4000);
    chk("R5 alias clear", rd_data, 32'h7FFE_FFFE);
    chk("R8 level after alias", {16'h0, cpu_level}, 32'h0000_7FFE);

    // R4 R6 plain clear of soft field, hardware bits untouched
    wr(1, 1, 32'h7FFF_FFFF);
    chk("R4 R6 clear write", rd_data, 32'h0000_FFFE);

    // R7 set wins over clear, clear alone works
    rtr(16'h0004, 16'h000C);
    chk("R7 set beats clear", rd_data, 32'h0000_FFF6);
    rtr(16'h0000, 16'hFFFF);
    chk("R7 router clear", rd_data, 32'h0000_0000);

    // R9 writes to word 0 and word 3 ignored
    wr(1, 2, 32'h0002_0000);
    wr(1, 0, 32'hFFFF_FFFF);
    chk("R9 word0 write ignored", rd_data, 32'h0002_0000);
    wr(1, 3, 32'hFFFF_FFFF);
    chk("R9 word3 write ignored", rd_data, 32'h0002_0000);

    // R10 invalid strobe ignored
    wr(0, 2, 32'hFFFF_FFFF);
    chk("R10 set with valid low", rd_data, 32'h0002_0000);
    wr(0, 1, 32'hFFFF_FFFF);
    chk("R10 clear with valid low", rd_data, 32'h0002_0000);

    // R8 router levels merged, line 0 from router only
    rtr_level = 16'h0101;
    step(); step();
    chk("R8 router merge", {16'h0, cpu_level}, 32'h0000_0103);
    rtr_level = 0;

    // R2 other words read zero
    for (int a = 1; a < 4; a++) begin
      rd_addr = a[1:0];
      #1;
      chk("R2 non-pending word reads zero", rd_data, 32'h0);
    end
    rd_addr = 0;

    // Random phase compared against the model each clock
    for (int n = 0; n < 4000; n++) begin
      wr_valid  = ($urandom_range(0, 3) != 0);
      wr_addr   = 2'($urandom_range(0, 3));
      wr_data   = $urandom();
      rtr_set   = ($urandom_range(0, 3) == 0) ? 16'($urandom()) : 16'h0;
      rtr_clr   = ($urandom_range(0, 3) == 0) ? 16'($urandom()) : 16'h0;
      rtr_level = ($urandom_range(0, 2) == 0) ? 16'($urandom()) : 16'h0;
      rd_addr   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      step();
    end
    idle_inputs();
    rtr_level = 0;
    rd_addr = 0;
    step(); step();
    chk("R8 level settles to model", {16'h0, cpu_level}, {16'h0, m_level});
    summary();
  end

endmodule